// File: doc/BRIEF.md
# Virtualized Feature-Test Gating Unit

This unit answers feature-test queries and decides whether optional instructions may run, for a core that can execute guest code in a virtual mode. A hypervisor keeps a private copy of the upper 32 feature bits. When the core is in virtual mode and the test-feature acceleration bit is set, queries read that private copy, and an optional instruction whose private bit is clear raises an illegal-operation fault, as on a core that lacks it. In every other case the physical feature bits answer the query and nothing is gated.

Each request carries a bit index and a decoded-instruction class. The answer, the fault flag and a valid strobe are registered one cycle later. A write port replaces the private feature bits. A write made while acceleration is enabled raises a one-cycle synchronization-required pulse.

Top module: `vfeat_gate`

## Requirements
- R1: While `rst_n` is low, the private feature bits load from `phys_feat`. In the first cycle after reset, `rsp_valid` and `sync_req` are 0. After reset, virtual-mode queries with acceleration on return the bits that `phys_feat` held during reset.
- R2: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise. A response in which `rsp_valid` is low has `rsp_hit` and `rsp_fault` at 0.
- R3: With `guest_mode`=1 and `accel_en`=1, a feature test (`req_cls`=0) for index i in 32..63 returns private bit i-32.
- R4: With `guest_mode`=1 and `accel_en`=0, a feature test for index i in 32..63 returns `phys_feat[i-32]`, and no class faults.
- R5: With `guest_mode`=0, a feature test returns `phys_feat[i-32]` whatever the value of `accel_en`, and no class faults.
- R6: A feature test for an index below 32 returns `rsp_hit`=0 and `rsp_fault`=0.
- R7: Class 1 (count leading zeros) faults exactly when `guest_mode`=1, `accel_en`=1 and private bit 0 (feature bit 32) is 0.
- R8: Classes 2 (4-byte multiply) and 3 (4-byte multiply-shift-left) fault exactly when `guest_mode`=1, `accel_en`=1 and private bit 1 (feature bit 33) is 0.
- R9: A write replaces all 32 private bits. A request in the same cycle as the write sees the old bits, and a request in the following cycle sees the new bits. A write updates the bits even when `accel_en`=0.
- R10: `sync_req` is high in the cycle after each write made with `accel_en`=1, and low at all other times.
- R11: The feature-test class and classes 4..7 never fault. For classes other than 0, `rsp_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| guest_mode | input | 1 | Core is running guest code in virtual mode |
| accel_en | input | 1 | Test-feature acceleration enable |
| phys_feat | input | 32 | Physical feature bits 63:32 |
| wr_en | input | 1 | Write strobe for the private feature bits |
| wr_data | input | 32 | New private feature bits 63:32 |
| req_valid | input | 1 | Request strobe |
| req_idx | input | 6 | Feature bit index being tested |
| req_cls | input | 3 | Instruction class: 0 test, 1 clz, 2 mpy4, 3 mpyshl4, 4..7 ungated |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Feature-test result |
| rsp_fault | output | 1 | Illegal-operation fault for a gated instruction |
| sync_req | output | 1 | Synchronization-required pulse after an accelerated write |

## Verification
The private feature bits are the only long-lived state. A corrupt or stale copy can only be seen through a later virtual-mode query with acceleration on. Such a corruption shows up as a wrong `rsp_hit` or a spurious or missing `rsp_fault` one cycle after that query, and a full index sweep exposes any single bad bit. Errors in the source select or in the gating show on the very next response. Errors in the write path show either as a wrong `sync_req` one cycle after the write or as wrong answers from the second cycle after it.

// File: rtl/vfg_pkg.sv
package vfg_pkg;
    localparam int CLS_W = 3;

    localparam logic [CLS_W-1:0] CLS_FTEST   = 3'd0;
    localparam logic [CLS_W-1:0] CLS_CLZ     = 3'd1;
    localparam logic [CLS_W-1:0] CLS_MPY4    = 3'd2;
    localparam logic [CLS_W-1:0] CLS_MPYSHL4 = 3'd3;

    // Gated instruction classes and the feature bit each one depends on
    localparam int N_GATED = 3;
    localparam logic [CLS_W-1:0] GATED_CLS [N_GATED] = '{CLS_CLZ, CLS_MPY4, CLS_MPYSHL4};
    localparam int GATED_BIT [N_GATED] = '{32, 33, 33};

    typedef struct packed {
        logic valid;
        logic hit;
        logic fault;
    } rsp_t;
endpackage

// File: rtl/vfg_feat_store.sv
module vfg_feat_store #(
    parameter int FEAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accel_en,
    input  logic [FEAT_W-1:0] phys_feat,
    input  logic              wr_en,
    input  logic [FEAT_W-1:0] wr_data,
    output logic [FEAT_W-1:0] vfeat,
    output logic              sync_req
);
    typedef struct packed {
        logic [FEAT_W-1:0] bits;
        logic              sync;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = wr_en & accel_en;
        if (wr_en) begin
            st_d.bits = wr_data;
        end
        if (!rst_n) begin
            st_d.bits = phys_feat;
            st_d.sync = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign vfeat    = st_q.bits;
    assign sync_req = st_q.sync;
endmodule

// File: rtl/vfg_bit_pick.sv
module vfg_bit_pick #(
    parameter int FEAT_W  = 32,
    parameter int FEAT_LO = 32,
    parameter int IDX_W   = 6
) (
    input  logic [FEAT_W-1:0] src,
    input  logic [IDX_W-1:0]  idx,
    output logic              hit
);
    // Indexes outside FEAT_LO..FEAT_LO+FEAT_W-1 match no entry and read 0
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < FEAT_W; i++) begin
            if (idx == IDX_W'(FEAT_LO + i)) begin
                hit = src[i];
            end
        end
    end
endmodule

// File: rtl/vfg_gate.sv
module vfg_gate
    import vfg_pkg::*;
#(
    parameter int FEAT_W  = 32,
    parameter int FEAT_LO = 32
) (
    input  logic              use_virt,
    input  logic [FEAT_W-1:0] vfeat,
    input  logic [CLS_W-1:0]  cls,
    output logic              fault
);
    logic [N_GATED-1:0] blocked;

    for (genvar g = 0; g < N_GATED; g++) begin : g_gate
        localparam int OFF = GATED_BIT[g] - FEAT_LO;
        assign blocked[g] = (cls == GATED_CLS[g]) && !vfeat[OFF];
    end

    assign fault = use_virt && (|blocked);
endmodule

// File: rtl/vfeat_gate.sv
module vfeat_gate
    import vfg_pkg::*;
#(
    parameter int FEAT_W  = 32,
    parameter int FEAT_LO = 32,
    parameter int IDX_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guest_mode,
    input  logic              accel_en,
    input  logic [FEAT_W-1:0] phys_feat,
    input  logic              wr_en,
    input  logic [FEAT_W-1:0] wr_data,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [CLS_W-1:0]  req_cls,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic              sync_req
);
    logic [FEAT_W-1:0] vfeat;
    logic [FEAT_W-1:0] src;
    logic              use_virt;
    logic              picked;
    logic              gate_fault;
    rsp_t              rsp_d, rsp_q;

    vfg_feat_store #(.FEAT_W(FEAT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .accel_en  (accel_en),
        .phys_feat (phys_feat),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .vfeat     (vfeat),
        .sync_req  (sync_req)
    );

    assign use_virt = guest_mode & accel_en;
    assign src      = use_virt ? vfeat : phys_feat;

    vfg_bit_pick #(.FEAT_W(FEAT_W), .FEAT_LO(FEAT_LO), .IDX_W(IDX_W)) u_pick (
        .src (src),
        .idx (req_idx),
        .hit (picked)
    );

    vfg_gate #(.FEAT_W(FEAT_W), .FEAT_LO(FEAT_LO)) u_gate (
        .use_virt (use_virt),
        .vfeat    (vfeat),
        .cls      (req_cls),
        .fault    (gate_fault)
    );

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.hit   = req_valid && (req_cls == CLS_FTEST) && picked;
        rsp_d.fault = req_valid && gate_fault;
        if (!rst_n) begin
            rsp_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_fault = rsp_q.fault;
endmodule

// File: rtl/vfg_chk.sv
module vfg_chk
    import vfg_pkg::*;
#(
    parameter int FEAT_W  = 32,
    parameter int FEAT_LO = 32,
    parameter int IDX_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              guest_mode,
    input logic              accel_en,
    input logic [FEAT_W-1:0] phys_feat,
    input logic              wr_en,
    input logic              req_valid,
    input logic [IDX_W-1:0]  req_idx,
    input logic [CLS_W-1:0]  req_cls,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_fault,
    input logic              sync_req
);
    logic phys_bit;
    logic in_range;

    always_comb begin
        phys_bit = 1'b0;
        in_range = 1'b0;
        for (int i = 0; i < FEAT_W; i++) begin
            if (req_idx == IDX_W'(FEAT_LO + i)) begin
                phys_bit = phys_feat[i];
                in_range = 1'b1;
            end
        end
    end

    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));
    a_r10_sync_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && accel_en) |=> sync_req);
    a_r10_sync_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |-> $past(wr_en && accel_en));
    a_r5_host_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !guest_mode) |=> !rsp_fault);
    a_r4_phys_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cls == CLS_FTEST && !accel_en && in_range) |=> (rsp_hit == $past(phys_bit)));
    a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cls == CLS_FTEST && !in_range) |=> (!rsp_hit && !rsp_fault));
    a_r11_ungated_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_cls == CLS_FTEST || req_cls > CLS_MPYSHL4)) |=> !rsp_fault);
endmodule

bind vfeat_gate vfg_chk #(.FEAT_W(FEAT_W), .FEAT_LO(FEAT_LO), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/vfeat_gate_bench.sv
module vfeat_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        guest_mode = 1'b0;
    logic        accel_en = 1'b0;
    logic [31:0] phys_feat = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_idx = '0;
    logic [2:0]  req_cls = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, sync_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] vmodel;

    typedef struct {
        logic  hit;
        logic  fault;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    vfeat_gate u_vfeat_gate (
        .clk(clk), .rst_n(rst_n), .guest_mode(guest_mode), .accel_en(accel_en),
        .phys_feat(phys_feat), .wr_en(wr_en), .wr_data(wr_data),
        .req_valid(req_valid), .req_idx(req_idx), .req_cls(req_cls),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .sync_req(sync_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request (caller sits at a negedge) and queue its expectation
    task automatic drive_req(input logic [5:0] idx, input logic [2:0] cls, input string tag);
        exp_t  e;
        logic  uv;
        logic [31:0] s;
        uv = guest_mode & accel_en;
        s  = uv ? vmodel : phys_feat;
        e.hit   = (cls == 3'd0 && idx >= 6'd32) ? s[idx[4:0]] : 1'b0;
        e.fault = uv && ((cls == 3'd1 && !vmodel[0]) ||
                         ((cls == 3'd2 || cls == 3'd3) && !vmodel[1]));
        e.tag   = tag;
        req_valid = 1'b1;
        req_idx   = idx;
        req_cls   = cls;
        sb.push_back(e);
    endtask

    task automatic issue(input logic [5:0] idx, input logic [2:0] cls, input string tag);
        drive_req(idx, cls, tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] d, input bit with_req,
                            input logic [5:0] idx, input logic [2:0] cls, input string tag);
        logic exp_sync;
        exp_sync = accel_en;
        wr_en    = 1'b1;
        wr_data  = d;
        if (with_req) drive_req(idx, cls, tag);
        else req_valid = 1'b0;
        @(negedge clk);
        check("R10 sync_req after write", {31'd0, sync_req}, {31'd0, exp_sync});
        wr_en     = 1'b0;
        req_valid = 1'b0;
        vmodel    = d;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R2 unexpected rsp_valid actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " rsp_hit"},   {31'd0, rsp_hit},   {31'd0, e.hit});
                    check({e.tag, " rsp_fault"}, {31'd0, rsp_fault}, {31'd0, e.fault});
                end
            end else begin
                check("R2 idle response quiet", {30'd0, rsp_hit, rsp_fault}, 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        phys_feat = 32'hA5A5_0F0F;
        vmodel    = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 sync_req after reset",  {31'd0, sync_req},  32'd0);

        // R1/R3: private bits hold the reset-time physical value
        phys_feat  = 32'h3C3C_5A5A;
        guest_mode = 1'b1;
        accel_en   = 1'b1;
        issue(6'd32, 3'd0, "R1");
        issue(6'd33, 3'd0, "R1");
        issue(6'd36, 3'd0, "R3");
        issue(6'd63, 3'd0, "R3");
        // R4: virtual mode, acceleration off
        accel_en = 1'b0;
        issue(6'd32, 3'd0, "R4");
        issue(6'd33, 3'd0, "R4");
        issue(6'd34, 3'd0, "R4");
        issue(6'd62, 3'd0, "R4");
        // R5: host mode reads physical bits even with acceleration on
        guest_mode = 1'b0;
        accel_en   = 1'b1;
        issue(6'd32, 3'd0, "R5");
        issue(6'd35, 3'd0, "R5");
        // R6: indexes below 32
        guest_mode = 1'b1;
        issue(6'd0,  3'd0, "R6");
        issue(6'd31, 3'd0, "R6");
        issue(6'd5,  3'd0, "R6");
        idle(2);

        // Clear bits 32 and 33 with acceleration on
        do_write(32'hFFFF_FFFC, 1'b0, 6'd0, 3'd0, "");
        issue(6'd32, 3'd1, "R7");
        issue(6'd40, 3'd2, "R8");
        issue(6'd40, 3'd3, "R8");
        issue(6'd40, 3'd4, "R11");
        issue(6'd40, 3'd7, "R11");
        issue(6'd32, 3'd0, "R3");
        issue(6'd34, 3'd0, "R3");
        guest_mode = 1'b0;
        issue(6'd32, 3'd1, "R5");
        issue(6'd32, 3'd2, "R5");
        guest_mode = 1'b1;
        accel_en   = 1'b0;
        issue(6'd32, 3'd1, "R4");
        issue(6'd32, 3'd3, "R4");
        idle(2);

        // Write with acceleration off: no pulse, bits still replaced
        do_write(32'h0000_0001, 1'b0, 6'd0, 3'd0, "");
        idle(1);
        check("R10 no pulse later", {31'd0, sync_req}, 32'd0);
        accel_en = 1'b1;
        issue(6'd32, 3'd1, "R9");
        issue(6'd32, 3'd2, "R8");
        issue(6'd32, 3'd3, "R8");
        issue(6'd32, 3'd0, "R9");
        idle(2);

        // Same-cycle request sees old bits; the next one sees new bits
        do_write(32'h0000_0002, 1'b1, 6'd32, 3'd1, "R9");
        issue(6'd32, 3'd1, "R9");
        issue(6'd33, 3'd2, "R9");
        idle(2);

        // Sweep every index against a scrambled private pattern
        do_write(32'h9E37_79B9, 1'b0, 6'd0, 3'd0, "");
        for (int i = 32; i < 64; i++) begin
            issue(6'(i), 3'd0, "R3");
        end
        accel_en = 1'b0;
        for (int i = 32; i < 64; i++) begin
            issue(6'(i), 3'd0, "R4");
        end
        idle(3);

        check("R2 scoreboard drained", sb.size(), 32'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule